// File: doc/BRIEF.md
# Endpoint Handshake and Data-Toggle Controller

This block decides, for a single endpoint, which reply the packet engine returns to the host, and it keeps the DATA0/DATA1 sequence for that endpoint. The CPU steers it with one-cycle command pulses. These set a stall, cancel a stall, restart the toggle at DATA0, or release a bank it has finished with. The packet engine reports what happens on the bus: a SETUP arrived, a token needs a reply, an OUT packet arrived with a given toggle and CRC result, or the host acknowledged an IN packet.

On every token the block returns one of four replies one cycle later: send data (IN only), ACK, NAK or STALL. It holds the next toggle to expect or to send. For OUT traffic it also keeps a record of the toggle of the last packet stored in each bank. The status field shows that record for the bank the CPU is working on, or the next toggle to send when the endpoint is viewed as IN. A SETUP cancels any pending stall, points the next data stage at DATA1 and captures the direction of that data stage.

Top module: `ep_hs_ctrl`

## Requirements
- R1: While the stall flag is set, an IN token, or an OUT packet with good CRC, gets the reply STALL (code 3) in the cycle after the token. A SETUP is always replied with ACK (code 1).
- R2: The stall flag is set by the stall-set pulse. It is cleared by the stall-clear pulse or by an accepted SETUP. A clear, from either source, wins over a set in the same cycle. The stall_active output shows the flag.
- R3: The toggle-reset pulse makes tog_next 0 (DATA0) in the next cycle, unless a SETUP is accepted in the same cycle.
- R4: An accepted SETUP makes tog_next 1 and sets ctrl_dir to the direction bit sent with the SETUP (1 = IN data stage, 0 = OUT), both in the next cycle. Nothing else changes ctrl_dir.
- R5: tog_status is 2 bits: 00 means DATA0 and 01 means DATA1, so bit 1 is always 0. When ep_is_in is 1 it shows tog_next. When ep_is_in is 0 it shows the toggle recorded for the bank the CPU is working on.
- R6: An OUT packet with good CRC, no stall, buffer ready and a toggle equal to tog_next gets ACK and is accepted. Acceptance inverts tog_next, records the toggle in the write bank and moves the write bank on. With a mismatching toggle the packet gets ACK but nothing changes.
- R7: With the buffer not ready and no stall, a token gets NAK (code 2) and the toggle holds. An OUT packet with bad CRC gets no reply and changes nothing.
- R8: An IN token with no stall and a ready buffer gets the reply "send data" (code 0), and tog_next gives the PID to use. tog_next inverts only on a host ACK for an IN packet.
- R9: While ep_enable is 0, SETUPs, tokens, OUT packets and host ACKs produce no reply and change no state. CPU commands still act.
- R10: After reset: no reply, stall clear, tog_next 0, ctrl_dir 0, both bank pointers at 0 and all recorded toggles 0.
- R11: The bank-release pulse moves the CPU bank pointer to the next bank, wrapping after the last of NUM_BANKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_enable | input | 1 | Endpoint takes part in transactions |
| ep_is_in | input | 1 | Status view select: 1 = IN view, 0 = OUT per-bank view |
| cpu_stall_set | input | 1 | Pulse: request stall |
| cpu_stall_clr | input | 1 | Pulse: cancel stall |
| cpu_tog_reset | input | 1 | Pulse: restart toggle at DATA0 |
| cpu_bank_release | input | 1 | Pulse: CPU is done with its current bank |
| pe_setup | input | 1 | SETUP packet received |
| pe_setup_dir_in | input | 1 | Data stage direction carried by the SETUP, 1 = IN |
| pe_tok_valid | input | 1 | Token awaiting a reply |
| pe_tok_in | input | 1 | Token is IN (1) or OUT data (0) |
| pe_buf_ready | input | 1 | Buffer has data (IN) or room (OUT) |
| pe_pkt_ok | input | 1 | OUT packet CRC good |
| pe_rx_tog | input | 1 | Toggle of the received OUT packet |
| pe_host_ack | input | 1 | Host acknowledged the IN packet |
| hs_valid | output | 1 | Reply valid |
| hs_code | output | 2 | Reply: 0 data, 1 ACK, 2 NAK, 3 STALL |
| tog_next | output | 1 | Next toggle expected (OUT) or to send (IN) |
| tog_status | output | 2 | Toggle status as in R5 |
| ctrl_dir | output | 1 | Data-stage direction captured from the last SETUP |
| stall_active | output | 1 | Stall flag |

## Verification
The hardest state to reach is a toggle record that differs from bank to bank while both bank pointers wrap. Reaching it needs accepted OUT packets, each with a toggle matching the running expectation, spread across bank releases. Random stimulus rarely lines these up. A directed run therefore accepts packets with the correct toggle, releases banks between them and checks the per-bank status view. Randomized traffic with a reference model then mixes in stall, clear, toggle-reset and SETUP pulses, including ones that land in the same cycle, to exercise the priorities.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
    typedef enum logic [1:0] {
        RPL_DATA  = 2'd0,
        RPL_ACK   = 2'd1,
        RPL_NAK   = 2'd2,
        RPL_STALL = 2'd3
    } reply_e;

    typedef struct packed {
        logic   stall;
        logic   tog;
        logic   ctrl_dir;
        logic   rpl_valid;
        reply_e rpl_code;
    } hs_state_t;
endpackage

// File: rtl/ep_reply_decide.sv
module ep_reply_decide
    import ep_hs_pkg::*;
(
    input  logic   enable,
    input  logic   setup,
    input  logic   tok_valid,
    input  logic   tok_in,
    input  logic   buf_ready,
    input  logic   pkt_ok,
    input  logic   stall,
    input  logic   rx_tog,
    input  logic   exp_tog,
    output logic   rpl_valid,
    output reply_e rpl_code,
    output logic   out_accept
);
    always_comb begin
        rpl_valid  = 1'b0;
        rpl_code   = RPL_DATA;
        out_accept = 1'b0;
        if (enable) begin
            if (setup) begin
                rpl_valid = 1'b1;
                rpl_code  = RPL_ACK;
            end else if (tok_valid) begin
                if (tok_in) begin
                    rpl_valid = 1'b1;
                    if (stall)           rpl_code = RPL_STALL;
                    else if (!buf_ready) rpl_code = RPL_NAK;
                    else                 rpl_code = RPL_DATA;
                end else if (pkt_ok) begin
                    rpl_valid = 1'b1;
                    if (stall)           rpl_code = RPL_STALL;
                    else if (!buf_ready) rpl_code = RPL_NAK;
                    else begin
                        rpl_code   = RPL_ACK;
                        out_accept = (rx_tog == exp_tog);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ep_tog_banks.sv
module ep_tog_banks #(
    parameter int NUM_BANKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_tog,
    input  logic rel,
    output logic cur_tog
);
    localparam int PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_BANKS - 1);

    typedef struct packed {
        logic [NUM_BANKS-1:0] rec;
        logic [PTR_W-1:0]     wr_ptr;
        logic [PTR_W-1:0]     rd_ptr;
    } bank_state_t;

    bank_state_t q, d;
    logic [NUM_BANKS-1:0] rec_d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign rec_d[b] = (wr_en && q.wr_ptr == PTR_W'(b)) ? wr_tog : q.rec[b];
    end

    always_comb begin
        d        = q;
        d.rec    = rec_d;
        if (wr_en) d.wr_ptr = bump(q.wr_ptr);
        if (rel)   d.rd_ptr = bump(q.rd_ptr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_tog = q.rec[q.rd_ptr];
endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
    import ep_hs_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ep_enable,
    input  logic       ep_is_in,
    input  logic       cpu_stall_set,
    input  logic       cpu_stall_clr,
    input  logic       cpu_tog_reset,
    input  logic       cpu_bank_release,
    input  logic       pe_setup,
    input  logic       pe_setup_dir_in,
    input  logic       pe_tok_valid,
    input  logic       pe_tok_in,
    input  logic       pe_buf_ready,
    input  logic       pe_pkt_ok,
    input  logic       pe_rx_tog,
    input  logic       pe_host_ack,
    output logic       hs_valid,
    output logic [1:0] hs_code,
    output logic       tog_next,
    output logic [1:0] tog_status,
    output logic       ctrl_dir,
    output logic       stall_active
);
    hs_state_t q, d;
    logic      rpl_valid;
    reply_e    rpl_code;
    logic      out_accept;
    logic      bank_tog;
    logic      setup_ok;

    assign setup_ok = ep_enable && pe_setup;

    ep_reply_decide u_decide (
        .enable     (ep_enable),
        .setup      (pe_setup),
        .tok_valid  (pe_tok_valid),
        .tok_in     (pe_tok_in),
        .buf_ready  (pe_buf_ready),
        .pkt_ok     (pe_pkt_ok),
        .stall      (q.stall),
        .rx_tog     (pe_rx_tog),
        .exp_tog    (q.tog),
        .rpl_valid  (rpl_valid),
        .rpl_code   (rpl_code),
        .out_accept (out_accept)
    );

    ep_tog_banks #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (out_accept),
        .wr_tog  (pe_rx_tog),
        .rel     (cpu_bank_release),
        .cur_tog (bank_tog)
    );

    always_comb begin
        d           = q;
        d.rpl_valid = rpl_valid;
        d.rpl_code  = rpl_code;

        if (setup_ok || cpu_stall_clr) d.stall = 1'b0;
        else if (cpu_stall_set)        d.stall = 1'b1;

        if (setup_ok) begin
            d.tog      = 1'b1;
            d.ctrl_dir = pe_setup_dir_in;
        end else if (cpu_tog_reset) begin
            d.tog = 1'b0;
        end else if (out_accept) begin
            d.tog = ~q.tog;
        end else if (ep_enable && pe_host_ack) begin
            d.tog = ~q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{stall: 1'b0, tog: 1'b0, ctrl_dir: 1'b0,
                           rpl_valid: 1'b0, rpl_code: RPL_DATA};
        else        q <= d;
    end

    assign hs_valid     = q.rpl_valid;
    assign hs_code      = q.rpl_code;
    assign tog_next     = q.tog;
    assign tog_status   = {1'b0, ep_is_in ? q.tog : bank_tog};
    assign ctrl_dir     = q.ctrl_dir;
    assign stall_active = q.stall;
endmodule

// File: rtl/ep_hs_ctrl_chk.sv
module ep_hs_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ep_enable,
    input logic       cpu_stall_clr,
    input logic       cpu_tog_reset,
    input logic       pe_setup,
    input logic       pe_setup_dir_in,
    input logic       pe_tok_valid,
    input logic       pe_tok_in,
    input logic       pe_buf_ready,
    input logic       pe_pkt_ok,
    input logic       pe_host_ack,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       tog_next,
    input logic       ctrl_dir,
    input logic       stall_active
);
    a_r1_stall_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_enable && pe_tok_valid && !pe_setup && stall_active && (pe_tok_in || pe_pkt_ok))
        |=> (hs_valid && hs_code == 2'd3));

    a_r2_setup_unstalls: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_enable && pe_setup) |=> !stall_active);

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall_clr |=> !stall_active);

    a_r3_tog_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tog_reset && !(ep_enable && pe_setup)) |=> !tog_next);

    a_r4_setup_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_enable && pe_setup) |=>
        (tog_next && hs_valid && hs_code == 2'd1 && ctrl_dir == $past(pe_setup_dir_in)));

    a_r7_nak_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_enable && pe_tok_valid && !pe_setup && !pe_tok_in && pe_pkt_ok && !stall_active
         && !pe_buf_ready && !cpu_tog_reset && !pe_host_ack)
        |=> (hs_valid && hs_code == 2'd2 && tog_next == $past(tog_next)));

    a_r8_in_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_enable && pe_tok_valid && !pe_setup && pe_tok_in && !stall_active
         && pe_buf_ready && !cpu_tog_reset && !pe_host_ack)
        |=> (hs_valid && hs_code == 2'd0 && tog_next == $past(tog_next)));

    a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_enable |=> !hs_valid);
endmodule

bind ep_hs_ctrl ep_hs_ctrl_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .ep_enable       (ep_enable),
    .cpu_stall_clr   (cpu_stall_clr),
    .cpu_tog_reset   (cpu_tog_reset),
    .pe_setup        (pe_setup),
    .pe_setup_dir_in (pe_setup_dir_in),
    .pe_tok_valid    (pe_tok_valid),
    .pe_tok_in       (pe_tok_in),
    .pe_buf_ready    (pe_buf_ready),
    .pe_pkt_ok       (pe_pkt_ok),
    .pe_host_ack     (pe_host_ack),
    .hs_valid        (hs_valid),
    .hs_code         (hs_code),
    .tog_next        (tog_next),
    .ctrl_dir        (ctrl_dir),
    .stall_active    (stall_active)
);

// File: tb/ep_hs_ctrl_test.sv
module ep_hs_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic en, is_in, s_set, s_clr, t_rst, b_rel;
    logic su, su_dir, tv, tin, br, pok, rxt, hack;
    logic       hs_valid, tog_next, ctrl_dir, stall_active;
    logic [1:0] hs_code, tog_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    bit       m_valid, m_stall, m_tog, m_dir;
    bit [1:0] m_code;
    bit       m_rec [NB];
    int       m_wr, m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_hs_ctrl #(.NUM_BANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .ep_enable(en), .ep_is_in(is_in),
        .cpu_stall_set(s_set), .cpu_stall_clr(s_clr), .cpu_tog_reset(t_rst),
        .cpu_bank_release(b_rel), .pe_setup(su), .pe_setup_dir_in(su_dir),
        .pe_tok_valid(tv), .pe_tok_in(tin), .pe_buf_ready(br), .pe_pkt_ok(pok),
        .pe_rx_tog(rxt), .pe_host_ack(hack), .hs_valid(hs_valid), .hs_code(hs_code),
        .tog_next(tog_next), .tog_status(tog_status), .ctrl_dir(ctrl_dir),
        .stall_active(stall_active)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [1:0] exp_status();
        return {1'b0, is_in ? m_tog : m_rec[m_rd]};
    endfunction

    task automatic model_reset();
        m_valid = 0; m_stall = 0; m_tog = 0; m_dir = 0; m_code = 0;
        foreach (m_rec[i]) m_rec[i] = 0;
        m_wr = 0; m_rd = 0;
    endtask

    task automatic model_step();
        bit acc = 0;
        bit su_ok = en && su;
        m_valid = 0; m_code = 0;
        if (en) begin
            if (su) begin m_valid = 1; m_code = 1; end
            else if (tv && tin) begin
                m_valid = 1;
                m_code = m_stall ? 2'd3 : (!br ? 2'd2 : 2'd0);
            end else if (tv && pok) begin
                m_valid = 1;
                m_code = m_stall ? 2'd3 : (!br ? 2'd2 : 2'd1);
                acc = !m_stall && br && (rxt == m_tog);
            end
        end
        if (acc) begin m_rec[m_wr] = rxt; m_wr = (m_wr + 1) % NB; end
        if (b_rel) m_rd = (m_rd + 1) % NB;
        if (su_ok || s_clr) m_stall = 0;
        else if (s_set)     m_stall = 1;
        if (su_ok) begin m_tog = 1; m_dir = su_dir; end
        else if (t_rst)       m_tog = 0;
        else if (acc)         m_tog = ~m_tog;
        else if (en && hack)  m_tog = ~m_tog;
    endtask

    task automatic idle();
        en = 1; is_in = 0; s_set = 0; s_clr = 0; t_rst = 0; b_rel = 0;
        su = 0; su_dir = 0; tv = 0; tin = 0; br = 0; pok = 0; rxt = 0; hack = 0;
    endtask

    task automatic compare(string tr, string tt, string ts, string tst, string td);
        chk(tr, hs_valid, m_valid);
        if (m_valid) chk(tr, hs_code, m_code);
        chk(tt, tog_next, m_tog);
        chk(ts, tog_status, exp_status());
        chk(tst, stall_active, m_stall);
        chk(td, ctrl_dir, m_dir);
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag, tag, tag, tag, tag);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare("R10", "R10", "R10", "R10", "R10");

        // R1 stall replies
        s_set = 1; step("R1");
        tv = 1; tin = 0; pok = 1; br = 1; rxt = 0; step("R1");
        tv = 1; tin = 1; br = 1; step("R1");
        su = 1; su_dir = 1; step("R2");
        // R2 clear beats set
        s_set = 1; step("R2");
        s_set = 1; s_clr = 1; step("R2");
        // R4 setup capture
        su = 1; su_dir = 0; step("R4");
        su = 1; su_dir = 1; tv = 1; tin = 1; br = 1; step("R4");
        // R6 accept with matching toggle (tog_next = 1)
        tv = 1; pok = 1; br = 1; rxt = 1; step("R6");
        tv = 1; pok = 1; br = 1; rxt = 1; step("R6");
        step("R5");
        // R11 bank release and per-bank record
        b_rel = 1; step("R11");
        tv = 1; pok = 1; br = 1; rxt = 0; step("R6");
        tv = 1; pok = 1; br = 1; rxt = 1; step("R6");
        b_rel = 1; step("R11");
        b_rel = 1; step("R11");
        is_in = 1; step("R5");
        // R3 toggle reset
        t_rst = 1; su = 1; step("R3");
        t_rst = 1; step("R3");
        // R7 NAK and bad CRC
        tv = 1; pok = 1; br = 0; rxt = 0; step("R7");
        tv = 1; pok = 0; br = 1; rxt = 0; step("R7");
        tv = 1; tin = 1; br = 0; step("R7");
        // R8 IN data and host ack
        tv = 1; tin = 1; br = 1; step("R8");
        hack = 1; step("R8");
        is_in = 1; step("R8");
        // R9 disabled endpoint
        en = 0; su = 1; su_dir = 0; step("R9");
        en = 0; tv = 1; pok = 1; br = 1; rxt = 1; step("R9");
        en = 0; hack = 1; step("R9");
        en = 0; s_set = 1; step("R9");
        s_clr = 1; step("R2");

        // randomized traffic
        for (int i = 0; i < 6000; i++) begin
            en     = ($urandom % 10) != 0;
            is_in  = $urandom % 2;
            s_set  = ($urandom % 12) == 0;
            s_clr  = ($urandom % 14) == 0;
            t_rst  = ($urandom % 16) == 0;
            b_rel  = ($urandom % 5) == 0;
            su     = ($urandom % 15) == 0;
            su_dir = $urandom % 2;
            tv     = ($urandom % 3) != 0;
            tin    = $urandom % 2;
            br     = ($urandom % 4) != 0;
            pok    = ($urandom % 6) != 0;
            rxt    = ($urandom % 4 == 0) ? ~m_tog : m_tog;
            hack   = ($urandom % 4) == 0;
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare("R8", "R6", "R5", "R2", "R4");
        end
        idle();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule